// File: doc/BRIEF.md
# Multi-Cycle 32-bit Load/Store Processor Core

This block runs a small 32-bit load/store instruction subset one instruction at a time. Each instruction passes through a short sequence of steps: fetch, decode, then one or more of execute, memory access, write-back and branch resolution. Only the steps an instruction class needs are visited, so different classes take different cycle counts. One adder/logic unit is shared by every step. It computes the next sequential address during fetch, a branch target during decode, the operation result during execute, and the equality test during branch resolution.

The core has a word-wide instruction port and a separate data port. Both are read combinationally within a step. A store raises the write strobe for exactly one cycle. Intermediate values are held in an instruction register, next-address, operand A/B, sign-extended immediate, ALU result and loaded-data registers. A 32-entry register file completes the datapath. No two instructions ever overlap.

Top module: `mc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to the fetch step with PC = 0. At the first sample after reset `imem_addr` is 0 and `dmem_we` is 0.
- R2: The first `dmem_we` pulse marks cycle counts. Counted from reset release, a load takes 5 cycles, a store 4, an R-type, add-immediate or upper-immediate operation 4, and a branch or jump 3. Fetch always advances PC by 4.
- R3: R-type (opcode bits 31:26 = 0x00, rs in 25:21, rt in 20:16, rd in 15:11, funct in 5:0) writes rd with: add for funct 0x20, subtract (rs - rt) for 0x22, AND for 0x24, OR for 0x25, and signed set-less-than for 0x2A.
- R4: Add-immediate (opcode 0x08) writes rt with rs plus the sign-extended 16-bit immediate in bits 15:0, wrapping modulo 2^32.
- R5: Upper-immediate (opcode 0x0F) writes rt with the immediate in bits 31:16 and zeros in bits 15:0.
- R6: Load word (opcode 0x23) reads data memory at rs + sign-extended immediate and writes that word to rt.
- R7: Store word (opcode 0x2B) presents address rs + sign-extended immediate and data rt. It holds `dmem_we` high for exactly one cycle, in its fourth step.
- R8: Branch-if-equal (opcode 0x04) and branch-if-not-equal (opcode 0x05) compare rs with rt. When the condition holds, PC becomes (address of branch + 4) + (sign-extended immediate << 2). Otherwise execution falls through. Backward offsets work.
- R9: Jump (opcode 0x02) sets PC to {bits 31:28 of (PC + 4), bits 25:0 of the instruction, 2'b00}.
- R10: Register 0 always reads as zero. Writes that target it, by load, immediate or R-type, are discarded.
- R11: An unrecognised opcode writes neither registers nor memory and completes in 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The bench builds the core with its default 32-entry register file and attaches 64-word instruction and data memories. Every word of instruction memory that no test fills holds a jump to its own address, so each program parks itself when it ends.

Operand pairs drawn from zero, one, small values, the signed extremes and all-ones are run through every R-type function. This covers signed comparison across the sign boundary and wrapping arithmetic. Immediates at the sign-extension boundaries are run through add-immediate and upper-immediate.

Equal and unequal operand pairs, including ones that differ only in the sign bit, exercise both branch conditions. A counted backward loop exercises negative branch offsets. The cycle of the first store strobe measures the step count of every instruction class, including an unrecognised opcode.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;
    localparam int HALF = XLEN / 2;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_RESOLVE
    } step_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_HIGH
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_ALU, CL_ADDI, CL_LUI, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_NONE
    } iclass_e;

    typedef struct packed {
        alu_op_e         op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } alu_req_t;

    function automatic iclass_e classify(input logic [5:0] op);
        case (op)
            OP_RTYPE:         return CL_ALU;
            OP_ADDI:          return CL_ADDI;
            OP_LUI:           return CL_LUI;
            OP_LOAD:          return CL_LOAD;
            OP_STORE:         return CL_STORE;
            OP_BEQ, OP_BNE:   return CL_BRANCH;
            OP_JUMP:          return CL_JUMP;
            default:          return CL_NONE;
        endcase
    endfunction

    function automatic alu_op_e funct_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           zero
);
    localparam int SHIFT = W / 2;

    always_comb begin
        case (op)
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_HIGH: y = b << SHIFT;
            default:  y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] store_q [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0)
            store_q[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : store_q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : store_q[raddr_b];

endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output step_e   step
);
    step_e nxt;

    always_comb begin
        nxt = ST_FETCH;
        case (step)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = (cls == CL_BRANCH || cls == CL_JUMP) ? ST_RESOLVE : ST_EXEC;
            ST_EXEC: begin
                case (cls)
                    CL_LOAD, CL_STORE:      nxt = ST_MEM;
                    CL_ALU, CL_ADDI, CL_LUI: nxt = ST_WB;
                    default:                nxt = ST_FETCH;
                endcase
            end
            ST_MEM:    nxt = (cls == CL_LOAD) ? ST_WB : ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= ST_FETCH;
        else     step <= nxt;
    end

    assert_wb_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WB) |=> (step == ST_FETCH));

    assert_resolve_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_RESOLVE) |=> (step == ST_FETCH));

endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int AW = $clog2(NREG);

    step_e           step;
    iclass_e         cls;
    alu_req_t        req;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, aluout_q, lmd_q;
    logic [XLEN-1:0] rf_a, rf_b, rf_wdata;
    logic [AW-1:0]   rf_waddr;
    logic            rf_we;
    logic            take;

    assign cls = classify(ir_q[31:26]);

    mc_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .cls  (cls),
        .step (step)
    );

    mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ir_q[21+AW-1:21]),
        .raddr_b (ir_q[16+AW-1:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    always_comb begin
        req = '{op: ALU_ADD, a: a_q, b: b_q};
        case (step)
            ST_FETCH: begin
                req.a = pc_q;
                req.b = XLEN'(4);
            end
            ST_DECODE: begin
                req.a = npc_q;
                req.b = sext16(ir_q[15:0]) << 2;
            end
            ST_EXEC: begin
                case (cls)
                    CL_ALU:                    req.op = funct_op(ir_q[5:0]);
                    CL_ADDI, CL_LOAD, CL_STORE: req.b = imm_q;
                    CL_LUI: begin
                        req.op = ALU_HIGH;
                        req.b  = imm_q;
                    end
                    default: ;
                endcase
            end
            ST_RESOLVE: req.op = ALU_SUB;
            default: ;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op   (req.op),
        .a    (req.a),
        .b    (req.b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign take = (ir_q[31:26] == OP_BEQ) ? alu_zero : !alu_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            npc_q    <= '0;
            ir_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            imm_q    <= '0;
            aluout_q <= '0;
            lmd_q    <= '0;
        end else begin
            case (step)
                ST_FETCH: begin
                    ir_q  <= imem_rdata;
                    npc_q <= alu_y;
                    pc_q  <= alu_y;
                end
                ST_DECODE: begin
                    a_q      <= rf_a;
                    b_q      <= rf_b;
                    imm_q    <= sext16(ir_q[15:0]);
                    aluout_q <= alu_y;
                end
                ST_EXEC:  aluout_q <= alu_y;
                ST_MEM:   if (cls == CL_LOAD) lmd_q <= dmem_rdata;
                ST_RESOLVE: begin
                    if (cls == CL_JUMP)
                        pc_q <= {npc_q[XLEN-1:28], ir_q[25:0], 2'b00};
                    else if (take)
                        pc_q <= aluout_q;
                end
                default: ;
            endcase
        end
    end

    assign rf_we    = (step == ST_WB);
    assign rf_waddr = (cls == CL_ALU) ? ir_q[11+AW-1:11] : ir_q[16+AW-1:16];
    assign rf_wdata = (cls == CL_LOAD) ? lmd_q : aluout_q;

    assign imem_addr  = pc_q;
    assign dmem_addr  = aluout_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = (step == ST_MEM) && (cls == CL_STORE);

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        if (rst_seen_q)
            assert_reset_pc_R1: assert (pc_q == '0 && step == ST_FETCH);
        rst_seen_q <= rst;
    end

    assert_fetch_adv_R2: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    assert_store_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    assert_zero_read_R10: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DECODE && ir_q[25:21] == 5'd0) |=> (a_q == '0));

    assert_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_RESOLVE && ir_q[31:26] == OP_BEQ && a_q != b_q) |=> $stable(imem_addr));

    assert_pc_align_R9: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);

endmodule

// File: tb/mc_cpu_tb.sv
module mc_cpu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [MW];
    logic [31:0] dmem [MW];

    int total = 0;
    int bad = 0;
    int first_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    mc_cpu u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, 26'(idx)};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", rq, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MW; i++) begin
            imem[i] = enc_j(i);
            dmem[i] = 32'd0;
        end
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        first_we = -1;
        for (int c = 0; c < n; c++) begin
            if (dmem_we === 1'b1) begin
                dmem[dmem_addr[7:2]] = dmem_wdata;
                if (first_we < 0) first_we = c;
            end
            @(negedge clk);
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pc", imem_addr, 32'd0);
        chk("R1 we", {31'd0, dmem_we}, 32'd0);
    endtask

    task automatic timing(input string rq, input logic [31:0] first, input int exp);
        clear_mem();
        imem[0] = first;
        if (first[31:26] != 6'h2B) imem[1] = enc_i(6'h2B, 0, 0, 16'd16);
        run(20);
        chk(rq, 32'(first_we), 32'(exp));
    endtask

    initial begin
        logic [31:0] vals [6];
        logic [5:0]  fns [5];
        logic [15:0] imms [6];
        vals = '{32'd0, 32'd1, 32'd7, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
        fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};

        reset_check();

        // R3: every function over every operand pair
        foreach (fns[f]) foreach (vals[i]) foreach (vals[j]) begin
            clear_mem();
            dmem[0] = vals[i];
            dmem[1] = vals[j];
            imem[0] = enc_i(6'h23, 0, 1, 16'd0);
            imem[1] = enc_i(6'h23, 0, 2, 16'd4);
            imem[2] = enc_r(1, 2, 3, fns[f]);
            imem[3] = enc_i(6'h2B, 0, 3, 16'd8);
            run(30);
            chk("R3 rtype", dmem[2], ref_alu(fns[f], vals[i], vals[j]));
        end

        reset_check();

        // R4 add-immediate, R5 upper-immediate
        foreach (vals[i]) foreach (imms[k]) begin
            clear_mem();
            dmem[0] = vals[i];
            imem[0] = enc_i(6'h23, 0, 1, 16'd0);
            imem[1] = enc_i(6'h08, 1, 4, imms[k]);
            imem[2] = enc_i(6'h2B, 0, 4, 16'd8);
            run(25);
            chk("R4 addi", dmem[2], vals[i] + {{16{imms[k][15]}}, imms[k]});
        end
        foreach (imms[k]) begin
            clear_mem();
            imem[0] = enc_i(6'h0F, 0, 5, imms[k]);
            imem[1] = enc_i(6'h2B, 0, 5, 16'd8);
            run(15);
            chk("R5 lui", dmem[2], {imms[k], 16'h0000});
        end

        // R6 / R7: negative and positive offsets from a base register
        clear_mem();
        dmem[5] = 32'hCAFE_BABE;
        imem[0] = enc_i(6'h08, 0, 1, 16'd24);
        imem[1] = enc_i(6'h23, 1, 2, 16'hFFFC);
        imem[2] = enc_i(6'h2B, 1, 2, 16'd4);
        run(25);
        chk("R6 load", dmem[7], 32'hCAFE_BABE);
        chk("R7 store untouched", dmem[6], 32'd0);

        // R8: both conditions over equal and unequal pairs
        for (int op = 4; op <= 5; op++) begin
            for (int p = 0; p < 4; p++) begin
                logic [31:0] x, y;
                logic taken;
                x = (p == 3) ? 32'h8000_0000 : 32'd5;
                y = (p == 0) ? 32'd5 : (p == 1) ? 32'd6 : (p == 2) ? 32'd5 : 32'd0;
                taken = (op == 4) ? (x == y) : (x != y);
                clear_mem();
                dmem[0] = x;
                dmem[1] = y;
                imem[0] = enc_i(6'h23, 0, 1, 16'd0);
                imem[1] = enc_i(6'h23, 0, 2, 16'd4);
                imem[2] = enc_i(6'h08, 0, 6, 16'd1);
                imem[3] = enc_i(6'(op), 1, 2, 16'd1);
                imem[4] = enc_i(6'h08, 0, 6, 16'd9);
                imem[5] = enc_i(6'h2B, 0, 6, 16'd8);
                run(40);
                chk("R8 branch", dmem[2], taken ? 32'd1 : 32'd9);
            end
        end

        // R8: backward branch loop of three passes
        clear_mem();
        imem[0] = enc_i(6'h08, 0, 1, 16'd3);
        imem[1] = enc_i(6'h08, 0, 2, 16'd0);
        imem[2] = enc_i(6'h08, 2, 2, 16'd5);
        imem[3] = enc_i(6'h08, 1, 1, 16'hFFFF);
        imem[4] = enc_i(6'h05, 1, 0, 16'hFFFD);
        imem[5] = enc_i(6'h2B, 0, 2, 16'd8);
        run(60);
        chk("R8 loop", dmem[2], 32'd15);

        // R9: jump over an instruction
        clear_mem();
        imem[0] = enc_i(6'h08, 0, 6, 16'd1);
        imem[1] = enc_j(3);
        imem[2] = enc_i(6'h08, 0, 6, 16'd7);
        imem[3] = enc_i(6'h2B, 0, 6, 16'd8);
        run(25);
        chk("R9 jump", dmem[2], 32'd1);

        // R10: writes to register 0 discarded, reads give zero
        clear_mem();
        dmem[0] = 32'h55;
        imem[0] = enc_i(6'h08, 0, 0, 16'd5);
        imem[1] = enc_i(6'h23, 0, 0, 16'd0);
        imem[2] = enc_r(0, 0, 0, 6'h25);
        imem[3] = enc_i(6'h2B, 0, 0, 16'd8);
        imem[4] = enc_i(6'h08, 0, 3, 16'h11);
        imem[5] = enc_i(6'h2B, 0, 3, 16'd12);
        dmem[2] = 32'hFFFF_FFFF;
        run(40);
        chk("R10 r0 store", dmem[2], 32'd0);
        chk("R10 r0 operand", dmem[3], 32'h11);

        // R11: unrecognised opcode leaves rt/rd unchanged
        clear_mem();
        dmem[0] = 32'h1234;
        imem[0] = enc_i(6'h23, 0, 3, 16'd0);
        imem[1] = {6'h3F, 5'd0, 5'd3, 5'd3, 5'd0, 6'h20};
        imem[2] = enc_i(6'h2B, 0, 3, 16'd8);
        run(25);
        chk("R11 no write", dmem[2], 32'h1234);

        // R2 / R7 / R11: step counts via the first store strobe
        timing("R2 load cycles",   enc_i(6'h23, 0, 1, 16'd0), 8);
        timing("R7 store cycles",  enc_i(6'h2B, 0, 0, 16'd16), 3);
        timing("R2 addi cycles",   enc_i(6'h08, 0, 1, 16'd3), 7);
        timing("R2 lui cycles",    enc_i(6'h0F, 0, 1, 16'd3), 7);
        timing("R2 rtype cycles",  enc_r(0, 0, 3, 6'h20), 7);
        timing("R2 beq cycles",    enc_i(6'h04, 0, 0, 16'd0), 6);
        timing("R2 bne cycles",    enc_i(6'h05, 0, 0, 16'd0), 6);
        timing("R2 jump cycles",   enc_j(1), 6);
        timing("R11 undef cycles", 32'hFC00_0000, 6);

        reset_check();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

endmodule